// File: doc/BRIEF.md
# Frame-Aligned Serial Receive Port with Voice Octet Split

This block accepts a serial bit stream, its bit clock and a frame marker from a line-side device. It samples all three with the local reference clock and finds the sampling edges of the bit clock, which can be the rising or the falling edge. It assembles the bits into octets whose boundaries are set by the frame marker. In each frame, a programmable number of octets at the start of the frame goes into a two-bank voice store. The other octets leave on a payload octet stream, each with a one-cycle valid strobe.

The voice store holds two banks, and they swap roles at every frame marker. One bank fills with octets from the current frame. The other bank holds the octets of the previous frame and serves a pop-style read port. Voice data therefore becomes readable one frame after it was captured. Three status outputs report conditions to the user. Two are sticky flags: one for voice octets dropped because there was no room, and one for reads made when no octet was available. The third reports that the bit clock has stopped.

Top module: `ser_rx_voice_split`

## Requirements
- R1: A sampling edge with the frame marker high starts a frame, and the data bit on that edge is discarded. The bit on the next sampling edge is the MSB of octet 0. Bits received before the first frame marker after reset are discarded.
- R2: With `clk_inv` = 0, data and marker are sampled on rising edges of `rx_sclk`. With `clk_inv` = 1, they are sampled on falling edges.
- R3: When `voice_cnt` = N (0 to 16), octets 0 to N-1 of each frame are written in order into the voice store. None of them appears on the payload stream.
- R4: Octets with index N or higher appear on `pay_data`, in arrival order, each with exactly one `pay_valid` cycle. When N = 0, every octet of the frame is payload.
- R5: Voice octets of a frame can be read only after the next frame marker. Each `vrd_en` cycle that finds an unread octet returns the next octet in capture order on `vrd_data`, with `vrd_valid` high one cycle later.
- R6: A `vrd_en` that finds no unread octet from the previous frame gives `vrd_valid` = 0 and sets `unf_flag`. The flag stays set until reset.
- R7: When `voice_cnt` is above 16, voice-indexed octets at index 16 or higher are dropped: they are neither stored nor sent as payload. `ovf_flag` is set and stays set until reset, and only 16 octets are readable.
- R8: `los` goes to 1 once 64 reference-clock cycles pass with no edge of either polarity on `rx_sclk`. It returns to 0 within a few cycles of the next edge.
- R9: After reset, `pay_valid`, `vrd_valid`, `ovf_flag`, `unf_flag` and `los` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sclk | input | 1 | Serial bit clock from the line side |
| rx_sdata | input | 1 | Serial data bit |
| rx_sfs | input | 1 | Frame marker, sampled like data |
| clk_inv | input | 1 | 0: rising-edge sampling, 1: falling-edge sampling |
| voice_cnt | input | 5 | Octets per frame steered to voice |
| pay_data | output | 8 | Payload octet |
| pay_valid | output | 1 | One-cycle strobe per payload octet |
| vrd_en | input | 1 | Pop one voice octet |
| vrd_data | output | 8 | Popped voice octet |
| vrd_valid | output | 1 | `vrd_data` holds a popped octet |
| ovf_flag | output | 1 | Sticky: voice octet dropped |
| unf_flag | output | 1 | Sticky: read with nothing available |
| los | output | 1 | Bit clock lost |

## Verification
The split is driven with several frame shapes. The cases are: a frame with no voice octets, short frames holding a few voice octets, a frame whose voice count equals the frame length, and a full 16-octet voice count with payload after it. Each octet value is derived from its index, so a shifted boundary, swapped order or lost octet shows up as a value mismatch rather than only a count mismatch. Vectors alternate the sampling edge, and the bench corrupts data and marker around the opposite edge, so a wrong edge choice destroys the frame. Further directed frames cover three cases: bits sent before the first marker, a read made before the bank swap, and a voice count above the store depth.

// File: rtl/ser_rx_pkg.sv
// Shared types for the frame-aligned serial receive port.
package ser_rx_pkg;
    localparam int OCTET_W = 8;
    typedef logic [OCTET_W-1:0]         octet_t;
    typedef logic [$clog2(OCTET_W)-1:0] bitpos_t;
endpackage

// File: rtl/ser_rx_edge.sv
// Brings the line-side bit clock, data and frame marker into the reference
// clock domain and produces a one-cycle strobe on each selected sampling edge.
// It also watches for a stopped bit clock.
// Assumes: the bit clock runs at well under a quarter of the reference clock,
// and data/marker are stable around the sampling edge.
module ser_rx_edge #(
    parameter int LOS_LIMIT = 64,
    parameter int SYNC_LEN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdata,
    input  logic sfs,
    input  logic clk_inv,
    output logic bit_stb,
    output logic bit_val,
    output logic bit_fs,
    output logic los
);
    localparam int LOS_W = $clog2(LOS_LIMIT + 1);

    logic [SYNC_LEN:0]   clk_sh;
    logic [SYNC_LEN-1:0] dat_sh;
    logic [SYNC_LEN-1:0] fs_sh;
    logic [LOS_W-1:0]    idle_cnt;
    logic                any_edge;

    // Synchronizer chains; the clock chain has one extra stage for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sh <= '0;
            dat_sh <= '0;
            fs_sh  <= '0;
        end else begin
            clk_sh <= {clk_sh[SYNC_LEN-1:0], sclk};
            dat_sh <= {dat_sh[SYNC_LEN-2:0], sdata};
            fs_sh  <= {fs_sh[SYNC_LEN-2:0], sfs};
        end
    end

    assign any_edge = clk_sh[SYNC_LEN] ^ clk_sh[SYNC_LEN-1];
    // Active edge: new level is 1 for rising sampling, 0 for falling sampling.
    assign bit_stb  = any_edge & (clk_sh[SYNC_LEN-1] ^ clk_inv);
    assign bit_val  = dat_sh[SYNC_LEN-1];
    assign bit_fs   = fs_sh[SYNC_LEN-1];

    // Counts reference cycles since the last bit-clock edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (any_edge) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LOS_W'(LOS_LIMIT)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign los = (idle_cnt == LOS_W'(LOS_LIMIT));
endmodule

// File: rtl/ser_rx_framer.sv
// Shifts sampled bits into octets. Octet boundaries restart at each frame
// marker, and the bit after the marker is the MSB. Each octet is tagged with
// its index within the frame, and the index saturates at its maximum.
// Assumes: bit strobes are at least two reference cycles apart.
module ser_rx_framer
    import ser_rx_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             bit_fs,
    output logic             oct_stb,
    output octet_t           oct_data,
    output logic [IDX_W-1:0] oct_idx,
    output logic             frame_stb
);
    localparam logic [IDX_W-1:0] IDX_MAX  = '1;
    localparam bitpos_t          LAST_BIT = bitpos_t'(OCTET_W - 1);

    logic             locked;
    bitpos_t          bit_cnt;
    octet_t           shreg;
    logic [IDX_W-1:0] idx;

    // Tracks frame alignment and emits completed octets with their index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked    <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            idx       <= '0;
            oct_stb   <= 1'b0;
            oct_data  <= '0;
            oct_idx   <= '0;
            frame_stb <= 1'b0;
        end else begin
            oct_stb   <= 1'b0;
            frame_stb <= 1'b0;
            if (bit_stb) begin
                if (bit_fs) begin
                    locked    <= 1'b1;
                    bit_cnt   <= '0;
                    idx       <= '0;
                    frame_stb <= 1'b1;
                end else if (locked) begin
                    shreg <= {shreg[OCTET_W-2:0], bit_val};
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt  <= '0;
                        oct_stb  <= 1'b1;
                        oct_data <= {shreg[OCTET_W-2:0], bit_val};
                        oct_idx  <= idx;
                        if (idx != IDX_MAX) begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ser_rx_voice_buf.sv
// Two-bank voice store. One bank fills during the current frame while the
// other, holding the previous frame's octets, is drained by pops. The banks
// swap at each frame marker. Writes beyond the depth are dropped and flag
// overflow; pops with nothing unread flag underflow. Both flags are sticky.
// Assumes: a write and a swap never occur in the same cycle.
module ser_rx_voice_buf
    import ser_rx_pkg::*;
#(
    parameter int VOICE_MAX = 16,
    parameter int VC_W      = 5,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  octet_t           wr_data,
    input  logic             swap,
    input  logic             rd_en,
    output octet_t           rd_data,
    output logic             rd_valid,
    output logic             ovf,
    output logic             unf
);
    localparam int AW = $clog2(VOICE_MAX);

    octet_t          mem_q [2][VOICE_MAX];
    logic            wr_sel;
    logic [VC_W-1:0] wr_cnt;
    logic [VC_W-1:0] rd_cnt;
    logic [VC_W-1:0] rd_ptr;
    logic            wr_fits;
    logic            rd_has;

    assign wr_fits = (wr_idx < IDX_W'(VOICE_MAX));
    assign rd_has  = (rd_ptr < rd_cnt);

    // Storage write into the bank currently being filled.
    always_ff @(posedge clk) begin
        if (wr_en && wr_fits) begin
            mem_q[wr_sel][wr_idx[AW-1:0]] <= wr_data;
        end
    end

    // Bank selection, fill and drain counters, read data and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel   <= 1'b0;
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            rd_ptr   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (wr_en) begin
                if (wr_fits) begin
                    wr_cnt <= VC_W'(wr_idx) + 1'b1;
                end else begin
                    ovf <= 1'b1;
                end
            end
            if (rd_en) begin
                if (rd_has) begin
                    rd_data  <= mem_q[~wr_sel][rd_ptr[AW-1:0]];
                    rd_valid <= 1'b1;
                    rd_ptr   <= rd_ptr + 1'b1;
                end else begin
                    unf <= 1'b1;
                end
            end
            if (swap) begin
                wr_sel <= ~wr_sel;
                rd_cnt <= wr_cnt;
                wr_cnt <= '0;
                rd_ptr <= '0;
            end
        end
    end
endmodule

// File: rtl/ser_rx_voice_split.sv
// Top of the frame-aligned serial receive port. It chains the edge finder,
// the octet framer and the voice store, and it steers each octet either to
// the voice store or to the registered payload output by its frame index.
// Assumes: voice_cnt changes only between frames.
module ser_rx_voice_split
    import ser_rx_pkg::*;
#(
    parameter int VOICE_MAX = 16,
    parameter int LOS_LIMIT = 64,
    localparam int VC_W     = $clog2(VOICE_MAX) + 1,
    localparam int IDX_W    = VC_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_sclk,
    input  logic            rx_sdata,
    input  logic            rx_sfs,
    input  logic            clk_inv,
    input  logic [VC_W-1:0] voice_cnt,
    output logic [7:0]      pay_data,
    output logic            pay_valid,
    input  logic            vrd_en,
    output logic [7:0]      vrd_data,
    output logic            vrd_valid,
    output logic            ovf_flag,
    output logic            unf_flag,
    output logic            los
);
    logic             bit_stb;
    logic             bit_val;
    logic             bit_fs;
    logic             oct_stb;
    octet_t           oct_data;
    logic [IDX_W-1:0] oct_idx;
    logic             frame_stb;
    logic             is_voice;

    ser_rx_edge #(
        .LOS_LIMIT (LOS_LIMIT),
        .SYNC_LEN  (2)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (rx_sclk),
        .sdata   (rx_sdata),
        .sfs     (rx_sfs),
        .clk_inv (clk_inv),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .bit_fs  (bit_fs),
        .los     (los)
    );

    ser_rx_framer #(
        .IDX_W (IDX_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .bit_fs    (bit_fs),
        .oct_stb   (oct_stb),
        .oct_data  (oct_data),
        .oct_idx   (oct_idx),
        .frame_stb (frame_stb)
    );

    assign is_voice = (oct_idx < IDX_W'(voice_cnt));

    ser_rx_voice_buf #(
        .VOICE_MAX (VOICE_MAX),
        .VC_W      (VC_W),
        .IDX_W     (IDX_W)
    ) u_vbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (oct_stb & is_voice),
        .wr_idx   (oct_idx),
        .wr_data  (oct_data),
        .swap     (frame_stb),
        .rd_en    (vrd_en),
        .rd_data  (vrd_data),
        .rd_valid (vrd_valid),
        .ovf      (ovf_flag),
        .unf      (unf_flag)
    );

    // Registers payload octets, i.e. octets past the voice region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_data  <= '0;
            pay_valid <= 1'b0;
        end else begin
            pay_valid <= oct_stb & ~is_voice;
            if (oct_stb && !is_voice) begin
                pay_data <= oct_data;
            end
        end
    end
endmodule

// File: rtl/ser_rx_voice_split_chk.sv
// Temporal checks on the receive port, attached to every instance by bind.
module ser_rx_voice_split_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_sclk,
    input logic pay_valid,
    input logic vrd_en,
    input logic vrd_valid,
    input logic ovf_flag,
    input logic unf_flag,
    input logic los
);
    // R4: a payload strobe lasts one cycle (octets are many cycles apart).
    assert_pay_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |=> !pay_valid);

    // R5: voice data appears only in answer to a read request.
    assert_rd_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_valid |-> $past(vrd_en));

    // R6: underflow is raised only by a read and then holds.
    assert_unf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_flag) |-> $past(vrd_en));
    assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag);

    // R7: overflow holds once raised.
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R8: a bit-clock edge clears loss of clock within three cycles.
    assert_los_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_sclk, 3) != $past(rx_sclk, 4)) |-> !los);
endmodule

bind ser_rx_voice_split ser_rx_voice_split_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_sclk   (rx_sclk),
    .pay_valid (pay_valid),
    .vrd_en    (vrd_en),
    .vrd_valid (vrd_valid),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag),
    .los       (los)
);

// File: tb/ser_rx_voice_split_tb.sv
`timescale 1ns/1ps
module ser_rx_voice_split_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sclk = 1'b0;
    logic       rx_sdata = 1'b0;
    logic       rx_sfs = 1'b0;
    logic       clk_inv = 1'b0;
    logic [4:0] voice_cnt = '0;
    logic [7:0] pay_data;
    logic       pay_valid;
    logic       vrd_en = 1'b0;
    logic [7:0] vrd_data;
    logic       vrd_valid;
    logic       ovf_flag;
    logic       unf_flag;
    logic       los;

    int  n_chk = 0;
    int  n_fail = 0;
    int  pay_n = 0;
    bit  done = 1'b0;
    logic [7:0] pay_q [256];

    always #2 clk = ~clk;

    ser_rx_voice_split u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_sclk   (rx_sclk),
        .rx_sdata  (rx_sdata),
        .rx_sfs    (rx_sfs),
        .clk_inv   (clk_inv),
        .voice_cnt (voice_cnt),
        .pay_data  (pay_data),
        .pay_valid (pay_valid),
        .vrd_en    (vrd_en),
        .vrd_data  (vrd_data),
        .vrd_valid (vrd_valid),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag),
        .los       (los)
    );

    // Payload monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n && pay_valid) begin
            pay_q[pay_n % 256] = pay_data;
            pay_n = pay_n + 1;
        end
    end

    // Vector fields: [31:24] voice count, [23:16] octets, [15:8] seed, [0] falling edge.
    localparam logic [31:0] VEC_TBL [5] = '{
        32'h00_04_3C_00,
        32'h02_05_A5_00,
        32'h10_12_11_01,
        32'h03_03_80_01,
        32'h01_06_F0_00
    };

    function automatic logic [7:0] oct_of(input logic [7:0] seed, input int i);
        return seed + 8'(i * 29);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bit: valid around the active edge, corrupted around the other one.
    task automatic send_bit(input logic b, input logic f);
        @(negedge clk);
        rx_sdata = b;
        rx_sfs   = f;
        step(2);
        rx_sclk = ~rx_sclk;
        step(2);
        rx_sdata = ~b;
        rx_sfs   = ~f;
        step(2);
        rx_sclk = ~rx_sclk;
        step(2);
        rx_sfs = 1'b0;
    endtask

    task automatic send_fs();
        send_bit(1'b1, 1'b1);
    endtask

    task automatic send_octet(input logic [7:0] o);
        for (int i = 7; i >= 0; i--) send_bit(o[i], 1'b0);
    endtask

    task automatic set_mode(input logic [4:0] vc, input logic inv);
        @(negedge clk);
        voice_cnt = vc;
        clk_inv   = inv;
        rx_sclk   = inv;
        step(4);
    endtask

    // Pops one voice octet; the result is visible at the next negedge.
    task automatic pop(output logic v, output logic [7:0] d);
        @(negedge clk);
        vrd_en = 1'b1;
        @(negedge clk);
        vrd_en = 1'b0;
        v = vrd_valid;
        d = vrd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic       v;
        logic [7:0] d;
        int         base;

        step(5);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        // R9: reset state.
        chk("R9", "pay_valid", 32'(pay_valid), 0);
        chk("R9", "vrd_valid", 32'(vrd_valid), 0);
        chk("R9", "ovf_flag", 32'(ovf_flag), 0);
        chk("R9", "unf_flag", 32'(unf_flag), 0);
        chk("R9", "los", 32'(los), 0);

        // R1: an octet sent before the first marker is discarded, the bit after it is the MSB.
        set_mode(5'd0, 1'b0);
        base = pay_n;
        send_octet(8'hFF);
        send_fs();
        send_octet(8'h5A);
        step(4);
        chk("R1", "payload count", 32'(pay_n - base), 1);
        chk("R1", "first octet", 32'(pay_q[base % 256]), 32'h5A);
        // R8: bit clock active, no loss.
        chk("R8", "los while active", 32'(los), 0);

        // Table walk: R2, R3, R4, R5.
        foreach (VEC_TBL[k]) begin
            int         vc;
            int         n;
            int         nv;
            logic [7:0] seed;
            vc   = int'(VEC_TBL[k][31:24]);
            n    = int'(VEC_TBL[k][23:16]);
            seed = VEC_TBL[k][15:8];
            nv   = (vc < n) ? vc : n;
            set_mode(5'(vc), VEC_TBL[k][0]);
            base = pay_n;
            send_fs();
            for (int i = 0; i < n; i++) send_octet(oct_of(seed, i));
            send_fs();
            step(4);
            // R4 (and R2 on falling-edge vectors): payload count and values.
            chk(VEC_TBL[k][0] ? "R2/R4" : "R4", "payload count", 32'(pay_n - base), 32'(n - nv));
            for (int j = 0; j < n - nv; j++)
                chk("R4", "payload octet", 32'(pay_q[(base + j) % 256]), 32'(oct_of(seed, nv + j)));
            // R3/R5: voice octets in capture order after the swap.
            for (int j = 0; j < nv; j++) begin
                pop(v, d);
                chk("R5", "voice valid", 32'(v), 1);
                chk("R3", "voice octet", 32'(d), 32'(oct_of(seed, j)));
            end
        end
        chk("R6", "no false underflow", 32'(unf_flag), 0);

        // R5/R6: voice is not readable before the swap; the read underflows.
        set_mode(5'd2, 1'b0);
        send_fs();
        send_octet(8'hC3);
        send_octet(8'h3C);
        step(4);
        pop(v, d);
        chk("R5", "read before swap valid", 32'(v), 0);
        chk("R6", "underflow raised", 32'(unf_flag), 1);
        send_fs();
        step(4);
        pop(v, d);
        chk("R5", "after swap octet 0", {23'd0, v, d}, 32'h1C3);
        pop(v, d);
        chk("R5", "after swap octet 1", {23'd0, v, d}, 32'h13C);
        pop(v, d);
        chk("R6", "drained read valid", 32'(v), 0);
        chk("R6", "underflow sticky", 32'(unf_flag), 1);

        // R7: voice count above depth drops octets 16..19.
        chk("R7", "no overflow yet", 32'(ovf_flag), 0);
        set_mode(5'd20, 1'b0);
        base = pay_n;
        send_fs();
        for (int i = 0; i < 22; i++) send_octet(oct_of(8'h47, i));
        send_fs();
        step(4);
        chk("R7", "overflow raised", 32'(ovf_flag), 1);
        chk("R7", "payload count", 32'(pay_n - base), 2);
        chk("R7", "payload first", 32'(pay_q[base % 256]), 32'(oct_of(8'h47, 20)));
        for (int j = 0; j < 16; j++) begin
            pop(v, d);
            chk("R7", "stored voice", {23'd0, v, d}, {23'd0, 1'b1, oct_of(8'h47, j)});
        end
        pop(v, d);
        chk("R7", "seventeenth read valid", 32'(v), 0);

        // R8: loss of clock after a long idle, cleared by an edge.
        step(100);
        chk("R8", "los after idle", 32'(los), 1);
        @(negedge clk);
        rx_sclk = ~rx_sclk;
        step(5);
        chk("R8", "los cleared", 32'(los), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule